// File: doc/BRIEF.md
# Dual-Edge Column Data Loader

This block fills a bank of 64 two-bit gray-shade column registers from two narrow pixel buses. One bus carries the value for an odd-numbered column and the other carries the value for the neighbouring even-numbered column. On every transition of the shift clock, rising or falling, one odd/even pair is stored. Storage happens only while the block's active chip-select input is high, so sixteen shift-clock periods load the whole bank.

Several loaders can be chained. A direction input decides which of the two chip-select pins listens and which one drives. It also decides whether the columns fill from 1 upward or from 64 downward. When the last pair has been stored, the driving pin goes high and enables the next loader. It stays high until the local chip-select falls. That same fall rewinds the fill position for the next line. Each bidirectional pin is brought out as a separate input, output value and output enable.

The shift clock and all data and select inputs are treated as synchronous to the system clock `clk`. An edge of `sclk` is seen at the first `clk` edge after it changes, and the pair is written at that same `clk` edge.

Top module: `column_loader`

## Requirements
- R1: While the active chip-select input is low, `sclk` transitions leave `col_data` unchanged. The active input is `cs_b_in` when `dir`=1 and `cs_a_in` when `dir`=0.
- R2: While the active chip-select input is high, a rising `sclk` transition stores one pair and a falling transition stores the next pair. The result appears at the first `clk` rising edge that samples the new `sclk` level.
- R3: Each store writes `din_odd` into an odd column and `din_even` into the even column next to it. Bit 1 of each bus is the MSB. Column c (1..64) sits at `col_data[2*(c-1)+1 : 2*(c-1)]`.
- R4: With `dir`=1, store k of a load (k = 0..31) writes columns 2k+1 (odd) and 2k+2 (even), which gives an ascending fill.
- R5: With `dir`=0, store k of a load writes columns 63-2k (odd) and 64-2k (even), which gives a descending fill.
- R6: After 32 stores, the cascade pin goes high at the same `clk` edge that writes the last pair. The cascade pin is `cs_a_out` when `dir`=1 and `cs_b_out` when `dir`=0.
- R7: The cascade pin has its output enable at 1. The active input pin has its output enable at 0 and its output value at 0.
- R8: The cascade pin stays high while the active input stays high. It falls one `clk` cycle after the active input is seen low, and the next load starts again at the first column of the fill order.
- R9: Transitions of `sclk` after the bank is full do not change `col_data`.
- R10: After reset, `col_data` is all zero and both chip-select output values are 0.
- R11: If the active input falls in the same `clk` cycle that an `sclk` transition is seen, nothing is stored. The following load still starts at the first column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | 1: `cs_b` listens, ascending fill; 0: `cs_a` listens, descending fill |
| sclk | input | 1 | Shift clock; both transitions store a pair |
| din_odd | input | 2 | Pixel value for the odd column, bit 1 is MSB |
| din_even | input | 2 | Pixel value for the even column, bit 1 is MSB |
| cs_a_in | input | 1 | Level seen on chip-select pin A |
| cs_a_out | output | 1 | Value driven on pin A |
| cs_a_oe | output | 1 | Drive enable for pin A |
| cs_b_in | input | 1 | Level seen on chip-select pin B |
| cs_b_out | output | 1 | Value driven on pin B |
| cs_b_oe | output | 1 | Drive enable for pin B |
| col_data | output | 128 | Column bank, two bits per column |

## Verification
Two things can land in the same `clk` cycle: the fall of the active chip-select and a shift-clock transition. The bench sets up that collision on purpose. It drops the select at the same negative clock edge where it toggles `sclk`, and it puts a new value on the buses. The bench then checks that `col_data` did not move. It also checks that the next store, after the select is raised again, lands in the first columns of the fill order and not where the interrupted load stopped. A second coincidence is the last store and the rise of the cascade pin. It is judged by comparing the bank and the cascade pin in the same sample.

// File: rtl/colload_pkg.sv
`timescale 1ns/1ps
package colload_pkg;
  localparam int unsigned DEF_NCOL = 64;
  localparam int unsigned DEF_PW   = 2;

  typedef enum logic {
    FILL_DOWN = 1'b0,
    FILL_UP   = 1'b1
  } fill_dir_e;
endpackage

// File: rtl/colload_rst_sync.sv
`timescale 1ns/1ps
module colload_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/colload_edge_det.sv
`timescale 1ns/1ps
module colload_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic sclk_edge
);
  logic sclk_q, sclk_d;

  always_comb sclk_d = sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

  // any transition, rising or falling
  assign sclk_edge = sclk ^ sclk_q;
endmodule

// File: rtl/colload_steer.sv
`timescale 1ns/1ps
module colload_steer
  import colload_pkg::*;
(
  input  logic dir,
  input  logic full,
  input  logic cs_a_in,
  input  logic cs_b_in,
  output logic cs_act,
  output logic cs_a_out,
  output logic cs_a_oe,
  output logic cs_b_out,
  output logic cs_b_oe
);
  fill_dir_e mode;

  always_comb begin
    mode     = fill_dir_e'(dir);
    cs_act   = 1'b0;
    cs_a_out = 1'b0;
    cs_a_oe  = 1'b0;
    cs_b_out = 1'b0;
    cs_b_oe  = 1'b0;
    unique case (mode)
      FILL_UP: begin
        cs_act   = cs_b_in;
        cs_a_oe  = 1'b1;
        cs_a_out = full;
      end
      FILL_DOWN: begin
        cs_act   = cs_a_in;
        cs_b_oe  = 1'b1;
        cs_b_out = full;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/colload_seq.sv
`timescale 1ns/1ps
module colload_seq
  import colload_pkg::*;
#(
  parameter int unsigned NPAIR = DEF_NCOL / 2,
  localparam int unsigned CW   = $clog2(NPAIR + 1),
  localparam int unsigned PIW  = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dir,
  input  logic           cs_act,
  input  logic           sclk_edge,
  output logic           cap,
  output logic [PIW-1:0] pair_idx,
  output logic           full
);
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PIW-1:0] pos;

  assign full = (cnt_q == CW'(NPAIR));
  assign cap  = cs_act && sclk_edge && !full;
  assign pos  = cnt_q[PIW-1:0];

  always_comb begin
    if (fill_dir_e'(dir) == FILL_UP) pair_idx = pos;
    else                              pair_idx = PIW'(NPAIR - 1) - pos;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!cs_act)  cnt_d = '0;
    else if (cap) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/colload_bank.sv
`timescale 1ns/1ps
module colload_bank
  import colload_pkg::*;
#(
  parameter int unsigned NCOL = DEF_NCOL,
  parameter int unsigned PW   = DEF_PW,
  localparam int unsigned NPAIR = NCOL / 2,
  localparam int unsigned PIW   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [PIW-1:0]   pair_idx,
  input  logic [PW-1:0]    din_odd,
  input  logic [PW-1:0]    din_even,
  output logic [NCOL*PW-1:0] col_data
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic          we;
    logic [PW-1:0] odd_q, even_q;

    assign we = cap && (pair_idx == PIW'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        odd_q  <= '0;
        even_q <= '0;
      end else if (we) begin
        odd_q  <= din_odd;
        even_q <= din_even;
      end
    end

    // column 2p+1 is odd, column 2p+2 is even
    assign col_data[(2*p)*PW   +: PW] = odd_q;
    assign col_data[(2*p+1)*PW +: PW] = even_q;
  end
endmodule

// File: rtl/column_loader.sv
`timescale 1ns/1ps
module column_loader
  import colload_pkg::*;
#(
  parameter int unsigned NCOL = DEF_NCOL,
  parameter int unsigned PW   = DEF_PW,
  localparam int unsigned NPAIR = NCOL / 2,
  localparam int unsigned PIW   = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir,
  input  logic               sclk,
  input  logic [PW-1:0]      din_odd,
  input  logic [PW-1:0]      din_even,
  input  logic               cs_a_in,
  output logic               cs_a_out,
  output logic               cs_a_oe,
  input  logic               cs_b_in,
  output logic               cs_b_out,
  output logic               cs_b_oe,
  output logic [NCOL*PW-1:0] col_data
);
  logic           rst_n_i;
  logic           sclk_edge;
  logic           cs_act;
  logic           cap;
  logic           full;
  logic [PIW-1:0] pair_idx;

  colload_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  colload_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sclk      (sclk),
    .sclk_edge (sclk_edge)
  );

  colload_steer u_steer (
    .dir      (dir),
    .full     (full),
    .cs_a_in  (cs_a_in),
    .cs_b_in  (cs_b_in),
    .cs_act   (cs_act),
    .cs_a_out (cs_a_out),
    .cs_a_oe  (cs_a_oe),
    .cs_b_out (cs_b_out),
    .cs_b_oe  (cs_b_oe)
  );

  colload_seq #(.NPAIR(NPAIR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .dir       (dir),
    .cs_act    (cs_act),
    .sclk_edge (sclk_edge),
    .cap       (cap),
    .pair_idx  (pair_idx),
    .full      (full)
  );

  colload_bank #(.NCOL(NCOL), .PW(PW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cap      (cap),
    .pair_idx (pair_idx),
    .din_odd  (din_odd),
    .din_even (din_even),
    .col_data (col_data)
  );
endmodule

// File: rtl/column_loader_chk.sv
`timescale 1ns/1ps
module column_loader_chk #(
  parameter int unsigned W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dir,
  input logic         cs_a_in,
  input logic         cs_b_in,
  input logic         cs_a_out,
  input logic         cs_b_out,
  input logic [W-1:0] col_data
);
  logic cs_act, casc;
  assign cs_act = dir ? cs_b_in  : cs_a_in;
  assign casc   = dir ? cs_a_out : cs_b_out;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable(col_data));  // R1

  AST_CASC_RISE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(casc) |-> $past(cs_act));  // R6

  AST_CASC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && cs_act && $stable(dir)) |=> casc);  // R8

  AST_CASC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !casc);  // R8

  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    casc |=> $stable(col_data));  // R9
endmodule

bind column_loader column_loader_chk #(.W(NCOL*PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir      (dir),
  .cs_a_in  (cs_a_in),
  .cs_b_in  (cs_b_in),
  .cs_a_out (cs_a_out),
  .cs_b_out (cs_b_out),
  .col_data (col_data)
);

// File: tb/sim_column_loader.sv
`timescale 1ns/1ps
module sim_column_loader;
  typedef struct packed {
    logic       dir;
    logic [7:0] seed;
    logic [5:0] ncap;
    logic       casc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h11, 6'd32, 1'b1},
    '{1'b0, 8'h5a, 6'd32, 1'b1},
    '{1'b1, 8'h3c, 6'd20, 1'b0},
    '{1'b0, 8'h96, 6'd7,  1'b0},
    '{1'b1, 8'he1, 6'd40, 1'b1},
    '{1'b0, 8'h2b, 6'd36, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir = 1'b1;
  logic         sclk = 1'b0;
  logic [1:0]   din_odd = '0;
  logic [1:0]   din_even = '0;
  logic         cs_a_in = 1'b0;
  logic         cs_b_in = 1'b0;
  logic         cs_a_out, cs_a_oe, cs_b_out, cs_b_oe;
  logic [127:0] col_data;

  int nchk = 0;
  int nfail = 0;
  logic [1:0] exp_col [64];

  always #5 clk = ~clk;

  column_loader u0 (
    .clk(clk), .rst_n(rst_n), .dir(dir), .sclk(sclk),
    .din_odd(din_odd), .din_even(din_even),
    .cs_a_in(cs_a_in), .cs_a_out(cs_a_out), .cs_a_oe(cs_a_oe),
    .cs_b_in(cs_b_in), .cs_b_out(cs_b_out), .cs_b_oe(cs_b_oe),
    .col_data(col_data)
  );

  function automatic logic [127:0] exp_flat();
    logic [127:0] f;
    for (int c = 0; c < 64; c++) f[2*c +: 2] = exp_col[c];
    return f;
  endfunction

  function automatic logic casc_pin(input logic d);
    return d ? cs_a_out : cs_b_out;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // model of store k: column numbers 1..64, index c-1
  task automatic put(input logic d, input int k, input logic [1:0] o, input logic [1:0] e);
    int odd_col;
    odd_col = d ? (2*k + 1) : (63 - 2*k);
    exp_col[odd_col - 1] = o;
    exp_col[odd_col]     = e;
  endtask

  task automatic cap(input logic [1:0] o, input logic [1:0] e);
    @(negedge clk);
    din_odd  = o;
    din_even = e;
    sclk     = ~sclk;
    @(negedge clk);
  endtask

  task automatic set_cs(input logic d, input logic v);
    @(negedge clk);
    dir     = d;
    cs_b_in = d ? v : 1'b0;
    cs_a_in = d ? 1'b0 : v;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #2000000;
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [127:0] snap;
    logic [7:0]   val;
    logic         was_low;
    for (int c = 0; c < 64; c++) exp_col[c] = 2'b00;

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 bank in reset", col_data, 128'd0);
    check("R10 cs outputs in reset", {126'd0, cs_a_out, cs_b_out}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 bank after release", col_data, 128'd0);

    // table walk: R3, R4, R5, R6, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      set_cs(v.dir, 1'b0);
      @(negedge clk);
      set_cs(v.dir, 1'b1);
      for (int k = 0; k < int'(v.ncap); k++) begin
        val = v.seed + 8'(k * 7);
        cap(val[1:0], val[3:2]);
        if (k < 32) put(v.dir, k, val[1:0], val[3:2]);
      end
      if (v.ncap > 6'd32)  check("R9 bank after extra stores", col_data, exp_flat());
      else if (v.dir)      check("R3/R4 ascending bank", col_data, exp_flat());
      else                 check("R3/R5 descending bank", col_data, exp_flat());
      check("R6 cascade level", {127'd0, casc_pin(v.dir)}, {127'd0, v.casc});
      if (v.dir) check("R7 pin roles dir=1", {125'd0, cs_a_oe, cs_b_oe, cs_b_out}, {125'd0, 3'b100});
      else       check("R7 pin roles dir=0", {125'd0, cs_b_oe, cs_a_oe, cs_a_out}, {125'd0, 3'b100});
      set_cs(v.dir, 1'b0);
      @(negedge clk);
      check("R8 cascade after select low", {127'd0, casc_pin(v.dir)}, 128'd0);
    end

    // R1: no stores while select low
    set_cs(1'b1, 1'b0);
    snap = col_data;
    for (int k = 0; k < 4; k++) cap(2'(k), 2'(3 - k));
    check("R1 select low ignores sclk", col_data, snap);

    // R11: select falls together with an sclk transition
    set_cs(1'b1, 1'b1);
    cap(2'b11, 2'b10); put(1'b1, 0, 2'b11, 2'b10);
    cap(2'b01, 2'b00); put(1'b1, 1, 2'b01, 2'b00);
    cap(2'b10, 2'b11); put(1'b1, 2, 2'b10, 2'b11);
    snap = col_data;
    @(negedge clk);
    cs_b_in  = 1'b0;
    sclk     = ~sclk;
    din_odd  = 2'b00;
    din_even = 2'b01;
    @(negedge clk);
    check("R11 no store at select fall", col_data, snap);
    cs_b_in = 1'b1;
    cap(2'b01, 2'b10); put(1'b1, 0, 2'b01, 2'b10);
    check("R11 restart at first column", col_data, exp_flat());

    // R2: one rising and one falling transition each store a pair
    was_low = (sclk == 1'b0);
    cap(2'b10, 2'b01); put(1'b1, 1, 2'b10, 2'b01);
    check(was_low ? "R2 rising edge store" : "R2 falling edge store", col_data, exp_flat());
    cap(2'b11, 2'b11); put(1'b1, 2, 2'b11, 2'b11);
    check(was_low ? "R2 falling edge store" : "R2 rising edge store", col_data, exp_flat());

    set_cs(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule